// File: doc/BRIEF.md
# Read-Invalidate Word Presenter for Wide Random Blocks

This block sits between a producer of 512-bit conditioned random blocks and a CPU register port that reads 32 bits at a time. It accepts one wide block through a valid/ready handshake. It then hands the block out as sixteen 32-bit words, each shown with a valid flag. A read strobe marks a word as consumed, and the next word, if one is ready, replaces it on the following clock edge.

The outputs come straight from flip-flops. Two word-sized registers sit between the wide block store and the port: a holding register that drives the port, and a staged next-word slot. The read strobe only moves these two small registers and the bank's 4-bit word pointer, so no combinational path runs from the bus strobe into the 512-bit store. The invalidation is still exact. In the cycle after a read, the port shows either the next never-read word with valid high, or valid low.

Software checks the valid flag before every read. A read issued while valid is low changes nothing.

Top module: `wordq_reader`

## Requirements
- R1: While reset is high, and in the first cycle after it, `rd_valid` is 0 and `blk_ready` is 1.
- R2: Words leave in acceptance order. Within a block, word i is `blk_data[32*i+31:32*i]`, starting at i = 0. Each accepted word is delivered exactly once.
- R3: After a clock edge at which `rd_strobe` and `rd_valid` were both high, the port shows the next undelivered word with `rd_valid` high, or `rd_valid` is low.
- R4: While `rd_valid` is high and `rd_strobe` is low, `rd_valid` stays high and `rd_data` stays unchanged at the next edge.
- R5: A strobe while `rd_valid` is low is ignored: no word is skipped or lost.
- R6: `blk_ready` is high only when the block store is empty. It drops in the cycle after a block is accepted. No more than 18 accepted words are ever outstanding.
- R7: A block accepted at edge E into an empty buffer shows its word 0 with `rd_valid` high right after edge E+2.
- R8: `rd_valid` and `rd_data` do not change when `rd_strobe` changes between clock edges.
- R9: With a read every cycle and a producer that is always ready, at most one cycle per 16-word block has `rd_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_data | input | 512 | Wide block from the producer |
| blk_valid | input | 1 | Producer offers `blk_data` |
| blk_ready | output | 1 | Block store is empty and will take a block |
| rd_strobe | input | 1 | Register read of the current word |
| rd_data | output | 32 | Current word |
| rd_valid | output | 1 | `rd_data` holds an unread word |

## Verification
The hardest case to reach is a block boundary: the last word of one block is read back-to-back while the next block is still entering the empty store, so the staged slot is briefly empty. A second hard case is a strobe that lands during that gap. The stimulus reaches both by reading on every cycle with an eager producer, then by reading on every other cycle, and then by random strobe spacing against a producer that goes idle at random. This sequence forces strobes while valid is low and drains the buffer completely. A queue model in the bench tracks every accepted word and is compared with the port on every clock.

// File: rtl/wordq_pkg.sv
package wordq_pkg;
    localparam int unsigned WQ_WORD_W = 32;

    typedef struct packed {
        logic                 vld;
        logic [WQ_WORD_W-1:0] data;
    } wq_word_t;

    function automatic wq_word_t wq_empty();
        wq_word_t w;
        w.vld  = 1'b0;
        w.data = '0;
        return w;
    endfunction
endpackage

// File: rtl/wordq_bank.sv
module wordq_bank
    import wordq_pkg::*;
#(
    parameter int unsigned BLOCK_W = 512
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [BLOCK_W-1:0] blk_data,
    input  logic               blk_valid,
    output logic               blk_ready,
    input  logic               take,
    output wq_word_t           head
);
    localparam int unsigned NW    = BLOCK_W / WQ_WORD_W;
    localparam int unsigned IDX_W = (NW > 1) ? $clog2(NW) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NW - 1);

    logic [BLOCK_W-1:0]   store;
    logic [IDX_W-1:0]     idx;
    logic                 full;
    logic [WQ_WORD_W-1:0] words [NW];

    for (genvar g = 0; g < NW; g++) begin : g_slice
        assign words[g] = store[g*WQ_WORD_W +: WQ_WORD_W];
    end

    assign blk_ready = !full;
    assign head.vld  = full;
    assign head.data = words[idx];

    always_ff @(posedge clk) begin
        if (!full && blk_valid) begin
            store <= blk_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            idx  <= '0;
        end else if (!full && blk_valid) begin
            full <= 1'b1;
            idx  <= '0;
        end else if (full && take) begin
            if (idx == LAST) begin
                full <= 1'b0;
                idx  <= '0;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/wordq_stage.sv
module wordq_stage
    import wordq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  wq_word_t             src,
    output logic                 src_take,
    input  logic                 rd_strobe,
    output logic [WQ_WORD_W-1:0] rd_data,
    output logic                 rd_valid
);
    wq_word_t hold_q;
    wq_word_t slot_q;
    logic     consume;
    logic     hold_free;
    logic     slot_move;
    logic     slot_free;

    assign consume   = rd_strobe && hold_q.vld;
    assign hold_free = !hold_q.vld || consume;
    assign slot_move = slot_q.vld && hold_free;
    assign slot_free = !slot_q.vld || slot_move;
    assign src_take  = src.vld && slot_free;

    assign rd_data  = hold_q.data;
    assign rd_valid = hold_q.vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= wq_empty();
            slot_q <= wq_empty();
        end else begin
            if (hold_free) begin
                hold_q <= slot_move ? slot_q : wq_empty();
            end
            if (slot_free) begin
                slot_q <= src_take ? src : wq_empty();
            end
        end
    end
endmodule

// File: rtl/wordq_reader.sv
module wordq_reader
    import wordq_pkg::*;
#(
    parameter int unsigned BLOCK_W = 512
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [BLOCK_W-1:0]   blk_data,
    input  logic                 blk_valid,
    output logic                 blk_ready,
    input  logic                 rd_strobe,
    output logic [WQ_WORD_W-1:0] rd_data,
    output logic                 rd_valid
);
    wq_word_t head;
    logic     take;

    wordq_bank #(.BLOCK_W(BLOCK_W)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .blk_data  (blk_data),
        .blk_valid (blk_valid),
        .blk_ready (blk_ready),
        .take      (take),
        .head      (head)
    );

    wordq_stage u_stage (
        .clk       (clk),
        .rst       (rst),
        .src       (head),
        .src_take  (take),
        .rd_strobe (rd_strobe),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );
endmodule

// File: rtl/wordq_reader_chk.sv
module wordq_reader_chk
    import wordq_pkg::*;
#(
    parameter int unsigned BLOCK_W = 512
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 blk_valid,
    input logic                 blk_ready,
    input logic                 rd_strobe,
    input logic [WQ_WORD_W-1:0] rd_data,
    input logic                 rd_valid
);
    localparam int NW    = int'(BLOCK_W / WQ_WORD_W);
    localparam int LIMIT = NW + 2;

    int pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 0;
        end else begin
            pending <= pending + ((blk_valid && blk_ready) ? NW : 0)
                               - ((rd_strobe && rd_valid) ? 1 : 0);
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> !rd_valid && blk_ready);

    p_valid_backed_r2: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> pending != 0);

    p_hold_steady_r4: assert property (@(posedge clk) disable iff (rst)
        rd_valid && !rd_strobe |=> rd_valid && $stable(rd_data));

    p_ready_drop_r6: assert property (@(posedge clk) disable iff (rst)
        blk_valid && blk_ready |=> !blk_ready);

    p_depth_r6: assert property (@(posedge clk) disable iff (rst)
        pending <= LIMIT);
endmodule

bind wordq_reader wordq_reader_chk #(.BLOCK_W(BLOCK_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .blk_valid (blk_valid),
    .blk_ready (blk_ready),
    .rd_strobe (rd_strobe),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
);

// File: tb/sim_wordq_reader.sv
`timescale 1ns/1ps
module sim_wordq_reader;
    localparam int BW = 512;
    localparam int NW = BW / 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [BW-1:0] blk_data = '0;
    logic          blk_valid = 1'b0;
    logic          blk_ready;
    logic          rd_strobe = 1'b0;
    logic [31:0]   rd_data;
    logic          rd_valid;

    int checks = 0;
    int fails  = 0;
    int blk_no = 0;
    int gap    = 0;
    int invalid_cnt = 0;
    logic [31:0] expq[$];
    logic prev_vld = 1'b0, prev_rd = 1'b0, prev_rd_inv = 1'b0, prev_acc = 1'b0;

    always #5 clk = ~clk;

    wordq_reader #(.BLOCK_W(BW)) u0 (
        .clk(clk), .rst(rst), .blk_data(blk_data), .blk_valid(blk_valid),
        .blk_ready(blk_ready), .rd_strobe(rd_strobe), .rd_data(rd_data),
        .rd_valid(rd_valid)
    );

    task automatic fail_msg(input string req, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
        fails++;
        $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) fail_msg(req, what, act, exp);
    endtask

    function automatic logic [BW-1:0] make_block(input int k);
        logic [BW-1:0] b;
        for (int i = 0; i < NW; i++) begin
            b[i*32 +: 32] = {k[15:0], 4'(i), 12'($urandom)};
        end
        return b;
    endfunction

    // compare port against the queue model, called at each negedge
    task automatic compare_now();
        string tag;
        tag = prev_rd ? "R3" : (prev_rd_inv ? "R5" : "R2");
        if (rd_valid) begin
            if (expq.size() == 0)
                chk(1'b0, "R2", "valid with no word pending", 32'(rd_valid), 32'd0);
            else
                chk(rd_data == expq[0], tag, "word mismatch", rd_data, expq[0]);
        end else begin
            chk(!(prev_vld && !prev_rd), "R4", "valid dropped without read",
                32'(rd_valid), 32'd1);
        end
        if (!rd_valid && expq.size() > 0) gap++; else gap = 0;
        chk(gap <= 3, "R2", "pending word not presented", 32'(gap), 32'd3);
        chk(expq.size() <= NW + 2, "R6", "outstanding words", 32'(expq.size()), 32'(NW + 2));
        if (prev_acc)
            chk(!blk_ready, "R6", "ready after acceptance", 32'(blk_ready), 32'd0);
        if (!rd_valid) invalid_cnt++;
    endtask

    // one clock: starts and ends at a negedge
    task automatic step(input logic s, input logic bv);
        logic ov;
        logic [31:0] od;
        logic acc, rdok, rdinv;
        compare_now();
        rd_strobe = s;
        blk_valid = bv;
        blk_data  = make_block(blk_no);
        #1;
        ov = rd_valid; od = rd_data;
        rd_strobe = !s;
        #1;
        chk(rd_valid == ov && rd_data == od, "R8", "output moved with strobe",
            rd_data, od);
        rd_strobe = s;
        #1;
        acc   = blk_valid && blk_ready;
        rdok  = s && rd_valid;
        rdinv = s && !rd_valid;
        @(posedge clk);
        if (rdok) void'(expq.pop_front());
        if (acc) begin
            for (int i = 0; i < NW; i++) expq.push_back(blk_data[i*32 +: 32]);
            blk_no++;
        end
        prev_vld = ov; prev_rd = rdok; prev_rd_inv = rdinv; prev_acc = acc;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] w0;
        repeat (3) @(negedge clk);
        chk(!rd_valid && blk_ready, "R1", "state in reset", {rd_valid, blk_ready}, 32'd1);
        rst = 1'b0;
        @(negedge clk);
        chk(!rd_valid && blk_ready, "R1", "state after reset", {rd_valid, blk_ready}, 32'd1);

        // R7: fill latency from an empty buffer
        step(1'b0, 1'b1);
        w0 = expq[0];
        chk(!rd_valid, "R7", "valid after E", 32'(rd_valid), 32'd0);
        step(1'b0, 1'b0);
        chk(!rd_valid, "R7", "valid after E+1", 32'(rd_valid), 32'd0);
        step(1'b0, 1'b0);
        chk(rd_valid && rd_data == w0, "R7", "word 0 after E+2", rd_data, w0);

        // every-cycle reads, eager producer; R9 throughput window
        for (int c = 0; c < 300; c++) begin
            if (c == 60) invalid_cnt = 0;
            step(1'b1, 1'b1);
            if (c == 231)
                chk(invalid_cnt <= 12, "R9", "low-valid cycles in 172", 32'(invalid_cnt), 32'd12);
        end

        // reads every second cycle
        for (int c = 0; c < 300; c++) step(1'(c % 2), 1'b1);

        // random spacing, producer with idle windows, strobes while invalid
        for (int c = 0; c < 3000; c++)
            step(1'($urandom_range(0, 2) == 0 || (c / 200) % 2 == 1),
                 1'($urandom_range(0, 9) < ((c / 300) % 2 == 0 ? 7 : 1)));

        // drain completely, strobing into an empty buffer
        for (int c = 0; c < 60; c++) step(1'b1, 1'b0);
        compare_now();
        chk(expq.size() == 0 && !rd_valid, "R5", "drained buffer", 32'(expq.size()), 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule